// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Register Access

This block is a bus-attached timer peripheral with four independent down-counters, each 32 bits wide. Each channel has its own 64-byte register window and its own interrupt line. Software stores a start value, copies it into the counter through a reload register, and sets the channel running. When the count reaches zero, the channel records a timeout.

In continuous mode the counter takes the start value again and keeps running. In single mode it stops and turns itself off. The interrupt line of a channel is its timeout status gated by a per-channel mask. The status is cleared through a short handshake: a busy flag stays up for two cycles, and the status drops only when that flag falls.

The register port follows the APB transfer phases with no wait states and no error response. Writes take effect at the clock edge that ends the access phase. Read data is driven combinationally during the access phase.

Top module: `mtmr_top`

## Requirements
- R1: After reset every channel has mode, start value, enable, count, status, busy and mask all at zero, and every interrupt line is low.
- R2: Channel n occupies byte addresses n*0x40 to n*0x40+0x3F. The register offsets inside a window are:
  - 0x00 status, bit 0, read-only
  - 0x04 mode, bit 0
  - 0x08 start value, 32 bits
  - 0x10 enable, bit 0
  - 0x14 reload, reads 0
  - 0x18 count, read-only
  - 0x20 clear: read bit 0 is status, read bit 1 is busy
  - 0x24 mask, bit 0

  Unmapped offsets read 0, and writes to them or to read-only registers change nothing.
- R3: A write of any value to the reload register copies the start value into the count at the next edge.
- R4: While enable is 1 and the count is not zero, the count drops by one each cycle. While enable is 0, the count holds.
- R5: In continuous mode (mode bit 0 = 0), an enabled count of zero causes, at the next edge, status = 1 and count = start value, and counting goes on.
- R6: In single mode (mode bit 0 = 1), an enabled count of zero causes, at the next edge, status = 1 and enable = 0, and the count stays at zero.
- R7: Writing 1 to bit 0 of the clear register sets busy for exactly 2 cycles. Status falls on the edge where busy falls. Writing 0 to bit 0 has no effect.
- R8: A clear write that arrives while busy is 1 is ignored: busy is not extended or restarted.
- R9: Each interrupt line equals that channel's status AND NOT its mask. A timeout sets status even while the mask is 1.
- R10: Channels are independent: activity on one channel leaves the registers and interrupt line of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address (channel index in bits 7:6) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq | output | 4 | One interrupt line per channel |

## Verification
A register write lands on the rising edge that ends its access phase (edge E). A read samples the state after the edge just before its access phase. The bench issues transfers back to back, two cycles each, so a read placed directly after a write observes the state after edge E+1, and each later read observes a state two edges further on. Every expected count, enable, status and busy value is therefore worked out from the number of edges since the enabling or clearing write: the count after edge E+j, the timeout on the edge after zero, and the fall of busy two edges after a clear. The scoreboard compares each value in the access phase of its own read. Interrupt lines are checked at the port half a cycle after the write that affects them.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    // register selected by the in-window offset
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MODE,
        SEL_LOAD,
        SEL_EN,
        SEL_RLD,
        SEL_CNT,
        SEL_CLR,
        SEL_MASK
    } reg_sel_e;

    localparam int WIN_W = 6;   // 64-byte window per channel

    function automatic reg_sel_e decode_off(input logic [WIN_W-1:0] off);
        case (off)
            6'h00:   decode_off = SEL_STAT;
            6'h04:   decode_off = SEL_MODE;
            6'h08:   decode_off = SEL_LOAD;
            6'h10:   decode_off = SEL_EN;
            6'h14:   decode_off = SEL_RLD;
            6'h18:   decode_off = SEL_CNT;
            6'h20:   decode_off = SEL_CLR;
            6'h24:   decode_off = SEL_MASK;
            default: decode_off = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mtmr_apb.sv
module mtmr_apb
    import mtmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = IDX_W + WIN_W
) (
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [DATA_W-1:0]     ch_rdata [NCH],
    output logic [NCH-1:0]        ch_wr,
    output reg_sel_e              sel,
    output logic [DATA_W-1:0]     prdata
);

    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             acc_wr;

    always_comb begin
        idx    = paddr[ADDR_W-1:WIN_W];
        idx_ok = (int'(idx) < NCH);
        sel    = decode_off(paddr[WIN_W-1:0]);
        acc_wr = psel && penable && pwrite;
        prdata = '0;
        ch_wr  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (idx_ok && (int'(idx) == i)) begin
                ch_wr[i] = acc_wr && (sel != SEL_NONE);
                if (psel && !pwrite) prdata = ch_rdata[i];
            end
        end
    end

endmodule

// File: rtl/mtmr_chan.sv
module mtmr_chan
    import mtmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    parameter int CLR_LAT = 2,
    parameter int BUSY_W  = $clog2(CLR_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    typedef struct packed {
        logic              mode;
        logic [CNT_W-1:0]  load;
        logic              en;
        logic [CNT_W-1:0]  cnt;
        logic              stat;
        logic              mask;
        logic [BUSY_W-1:0] busy;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     tmo;

    always_comb begin
        s_d = s_q;
        tmo = s_q.en && (s_q.cnt == '0);
        // counting and timeout
        if (tmo) begin
            if (s_q.mode) s_d.en  = 1'b0;
            else          s_d.cnt = s_q.load;
        end else if (s_q.en) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        // clear handshake countdown
        if (s_q.busy != '0) begin
            s_d.busy = s_q.busy - 1'b1;
            if (s_q.busy == BUSY_W'(1)) s_d.stat = 1'b0;
        end
        // register writes
        if (wr) begin
            case (sel)
                SEL_MODE: s_d.mode = wdata[0];
                SEL_LOAD: s_d.load = wdata[CNT_W-1:0];
                SEL_EN:   s_d.en   = wdata[0];
                SEL_RLD:  s_d.cnt  = s_q.load;
                SEL_CLR:  if (wdata[0] && (s_q.busy == '0)) s_d.busy = BUSY_W'(CLR_LAT);
                SEL_MASK: s_d.mask = wdata[0];
                default:  ;
            endcase
        end
        // a new timeout wins over a finishing clear
        if (tmo) s_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (sel)
            SEL_STAT: rdata = DATA_W'(s_q.stat);
            SEL_MODE: rdata = DATA_W'(s_q.mode);
            SEL_LOAD: rdata = DATA_W'(s_q.load);
            SEL_EN:   rdata = DATA_W'(s_q.en);
            SEL_CNT:  rdata = DATA_W'(s_q.cnt);
            SEL_CLR:  rdata = DATA_W'({(s_q.busy != '0), s_q.stat});
            SEL_MASK: rdata = DATA_W'(s_q.mask);
            default:  rdata = '0;
        endcase
    end

    assign irq = s_q.stat & ~s_q.mask;

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && (s_q.cnt != '0) && !(wr && sel == SEL_RLD))
        |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_RLD) |=> (s_q.cnt == $past(s_q.load)));

    // R5
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !s_q.mode && !(wr && sel == SEL_RLD))
        |=> (s_q.cnt == $past(s_q.load)) && s_q.stat);

    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && s_q.mode && !(wr && sel == SEL_EN)) |=> (!s_q.en && s_q.stat));

    // R7
    stat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.stat) |-> ($past(s_q.busy) == BUSY_W'(1)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_CLR && s_q.busy != '0)
        |=> (s_q.busy == $past(s_q.busy) - 1'b1));

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    parameter int CLR_LAT = 2,
    localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = IDX_W + WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NCH-1:0]    irq
);

    logic [DATA_W-1:0] ch_rdata [NCH];
    logic [NCH-1:0]    ch_wr;
    reg_sel_e          sel;

    mtmr_apb #(
        .NCH(NCH), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_apb (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .ch_rdata(ch_rdata), .ch_wr(ch_wr), .sel(sel), .prdata(prdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mtmr_chan #(
            .CNT_W(CNT_W), .DATA_W(DATA_W), .CLR_LAT(CLR_LAT)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .wr(ch_wr[g]), .sel(sel),
            .wdata(pwdata), .rdata(ch_rdata[g]), .irq(irq[g])
        );
    end

    // R10
    one_chan_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr));

endmodule

// File: tb/sim_mtmr_top.sv
`timescale 1ns/1ps
module sim_mtmr_top;

    localparam logic [7:0] O_STAT = 8'h00, O_MODE = 8'h04, O_LOAD = 8'h08,
                           O_EN = 8'h10, O_RLD = 8'h14, O_CNT = 8'h18,
                           O_CLR = 8'h20, O_MASK = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] e;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    function automatic logic [7:0] ra(input int ch, input logic [7:0] off);
        ra = 8'(ch * 8'h40) + off;
    endfunction

    task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = ra(ch, off); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
    endtask

    task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
    endtask

    task automatic rd_raw(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
    endtask

    task automatic rd(input int ch, input logic [7:0] off, input logic [31:0] e, input string tag);
        rd_raw(ra(ch, off), e, tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        for (int k = 1; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic chk_irq(input int ch, input logic e, input string tag);
        total++;
        if (irq[ch] !== e) begin
            bad++;
            $display("FAIL %s irq[%0d] actual=%0b expected=%0b", tag, ch, irq[ch], e);
        end
    endtask

    // monitor: compare every read in its access phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (psel && penable && !pwrite) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL scoreboard unexpected read addr=%h actual=%h expected=none", paddr, prdata);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    if (prdata !== it.e || paddr !== it.a) begin
                        bad++;
                        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, paddr, prdata, it.e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(0, 1'b0, "R1"); chk_irq(3, 1'b0, "R1");
        rd(0, O_LOAD, 0, "R1 load"); rd(0, O_CNT, 0, "R1 count");
        rd(2, O_MODE, 0, "R1 mode"); rd(2, O_EN, 0, "R1 enable");
        rd(3, O_MASK, 0, "R1 mask"); rd(1, O_CLR, 0, "R1 status/busy");

        // R5 continuous on ch0, start 5; enable lands on edge E
        wr(0, O_LOAD, 5); wr(0, O_RLD, 0); wr(0, O_EN, 1);
        rd(0, O_CNT, 4, "R4 count after E+1");
        rd(0, O_CNT, 2, "R4 count after E+3");
        rd(0, O_CNT, 0, "R5 count after E+5");
        rd(0, O_CNT, 4, "R5 wrap then count after E+7");
        rd(0, O_STAT, 1, "R5 status set");

        // R3 reload with arbitrary written values, ch3 never enabled
        wr(3, O_LOAD, 7); wr(3, O_RLD, 0);
        rd(3, O_CNT, 7, "R3 reload by 0");
        wr(3, O_LOAD, 9); wr(3, O_RLD, 32'hFFFF);
        rd(3, O_CNT, 9, "R3 reload by FFFF");
        idle(10);
        rd(3, O_CNT, 9, "R4 held while disabled");

        // R2 unmapped and read-only
        rd(0, 8'h0C, 0, "R2 unmapped 0x0C");
        rd(1, 8'h30, 0, "R2 unmapped 0x30");
        rd(3, O_RLD, 0, "R2 reload reads 0");
        wr_raw(ra(3, 8'h0C), 32'hDEAD);
        wr(3, O_CNT, 32'h55);
        wr(3, O_STAT, 1);
        rd(3, O_LOAD, 9, "R2 load untouched");
        rd(3, O_CNT, 9, "R2 count read-only");
        rd(3, O_STAT, 0, "R2 status read-only");
        rd(0, 8'h04 + 8'h40 * 0, 0, "R2 ch0 mode still continuous");

        // R6 single on ch1, start 2
        wr(1, O_MODE, 1); wr(1, O_LOAD, 2); wr(1, O_RLD, 0); wr(1, O_EN, 1);
        rd(1, O_CNT, 1, "R6 count after E+1");
        rd(1, O_EN, 0, "R6 enable cleared after timeout");
        rd(1, O_CNT, 0, "R6 count stays zero");
        rd(1, O_STAT, 1, "R6 status set");
        idle(1);
        chk_irq(1, 1'b1, "R9 unmasked irq");

        // R7 clear handshake
        wr(1, O_CLR, 0);
        rd(1, O_CLR, 1, "R7 write 0 no effect");
        wr(1, O_CLR, 1);
        rd(1, O_CLR, 3, "R7 busy with status after C+1");
        rd(1, O_CLR, 0, "R7 cleared after C+3");
        idle(1);
        chk_irq(1, 1'b0, "R7 irq dropped");

        // R8 clear while busy ignored
        wr(1, O_RLD, 0); wr(1, O_EN, 1);
        idle(6);
        rd(1, O_STAT, 1, "R8 status set again");
        wr(1, O_CLR, 1); wr(1, O_CLR, 1);
        rd(1, O_CLR, 0, "R8 busy not extended");

        // R9 masked timeout on ch2, start 0
        wr(2, O_MODE, 1); wr(2, O_MASK, 1); wr(2, O_LOAD, 0);
        wr(2, O_RLD, 0); wr(2, O_EN, 1);
        rd(2, O_STAT, 1, "R9 status set while masked");
        idle(1);
        chk_irq(2, 1'b0, "R9 masked irq low");
        wr(2, O_MASK, 0);
        idle(1);
        chk_irq(2, 1'b1, "R9 unmasked irq high");

        // R10 independence
        chk_irq(3, 1'b0, "R10 ch3 irq");
        rd(3, O_CNT, 9, "R10 ch3 count");
        rd(3, O_MODE, 0, "R10 ch3 mode");
        rd(1, O_MASK, 0, "R10 ch1 mask");

        idle(3);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule